// File: doc/BRIEF.md
# Synchronous Rectifier Gate-Shrink Arbiter

This block sits beside the gate timer of a two-phase synchronous rectifier controller on the secondary side of a resonant converter. The gate timer predicts each cycle's on-time from the previous cycle's conduction time. That prediction fails during fast load or line transients. This block watches for three transient signatures and tells the gate timer how many clock ticks to trim from the coming on-time, so that the rectifier switch opens before the primary side commutates.

The three detectors each have their own shrink amount and lifetime.

- **Dead-time detector.** It flags a dead time that was too short: the detect-low input deasserts just after the gate dropped.
- **Feedback-growth detector.** It flags a per-cycle feedback magnitude that grew by more than a fifth over the previous sample.
- **Ringing detector.** It flags the detect-low input bouncing around zero: a brief assertion, followed by a sustained deassertion.

The dead-time and ringing findings are armed when detected and take effect for exactly one switching cycle, starting at the next cycle-start strobe. The feedback finding takes effect at once and lasts for a fixed hold time, and a fresh trigger restarts that hold. The output is the largest of the amounts in force; the amounts are never added.

All windows, hold times and amounts are parameters in clock ticks. At the default 5 ns tick they are:

| Quantity | Ticks | Time |
|---|---|---|
| Dead-time window | 25 | 125 ns |
| Ringing window | 70 | 350 ns |
| Ringing hold | 30 | 150 ns |
| Dead-time shrink | 250 | 1.25 µs |
| Feedback shrink | 280 | 1.4 µs |
| Ringing shrink | 240 | 1.2 µs |
| Feedback hold | 18000 | 90 µs |

Top module: `srs_shrink_arb`

## Requirements
- R1: While reset is low, and after its release, `shrink_o` is 0 and the stored previous feedback value is 0. Consequence: the first strobed feedback word after reset that is nonzero counts as growth.
- R2: A dead-time event is recorded when the edge that sees the gate fall is also the edge that sees detect-low fall, or when detect-low's fall is seen at most DW_TICKS edges after that gate-fall edge. A later fall records nothing.
- R3: A recorded dead-time or ringing event produces no shrink until the next cycle-start strobe. From that strobe it holds for one cycle. It is dropped at the strobe after.
- R4: A strobed feedback word triggers the feedback shrink only when 5×new is strictly greater than 6×previous. A growth of exactly 20% does not trigger.
- R5: A feedback trigger makes `shrink_o` at least FD_SHRINK from the edge that samples the strobe, for exactly FD_HOLD cycles. A new trigger while it is active restarts the full FD_HOLD.
- R6: The previous feedback value is replaced on every strobe, whether or not that strobe triggered.
- R7: A ringing event is recorded when detect-low deasserts at most RING_WIN edges after it asserted and then stays deasserted for RING_HOLD further edges. A reassertion during those edges cancels the detection.
- R8: A ringing event shrinks the cycle after the next cycle-start strobe by RNG_SHRINK, with the one-cycle lifetime of R3.
- R9: With several sources active, `shrink_o` equals the largest active amount, never a sum. With none active it is 0.
- R10: `fb_word_i` is ignored while `fb_val_i` is low: neither the stored previous value nor the shrink changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Current state of the rectifier gate drive |
| detl_i | input | 1 | High while the switch's drain-source voltage is below the low threshold |
| fb_val_i | input | 1 | Strobe marking a new per-cycle feedback magnitude |
| fb_word_i | input | FB_W | Feedback magnitude for the current cycle |
| cyc_start_i | input | 1 | Strobe at the start of each switching cycle |
| shrink_o | output | SHR_W | On-time reduction in clock ticks for the gate timer |

## Verification
The bench sweeps the gate-fall to detect-low-fall distance across the window edge, including the same-edge case. An off-by-one window would shrink one distance too many or one too few. It sweeps the ringing pulse width against its window and the low hold against its threshold. A detector that ignored the hold, or measured it one short, would trim on harmless single-edge glitches.

Every previous/new feedback pair over a small range is checked against the strict 5:6 comparison. A design using ≥, or dropping a product bit, misfires at exact 20% steps. The exact hold length and a mid-hold restart are counted; a timer that failed to reload would end early.

Simultaneous sources are checked against the maximum, which exposes an adder in place of the selector. Unstrobed words are checked for not disturbing the stored value, and a non-triggering strobe for still replacing it.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Sources that live for exactly one switching cycle
  localparam int unsigned NUM_CYC_SRC = 2;
  localparam int unsigned SRC_DT      = 0;
  localparam int unsigned SRC_RNG     = 1;

  // Total number of shrink sources fed to the selector
  localparam int unsigned NUM_SRC     = NUM_CYC_SRC + 1;

  typedef enum logic [1:0] {
    RG_IDLE = 2'd0,
    RG_WIN  = 2'd1,
    RG_HOLD = 2'd2
  } ring_state_e;

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/srs_deadtime_det.sv
module srs_deadtime_det #(
  parameter int unsigned DW_TICKS = 25,
  localparam int unsigned CW = $clog2(DW_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_fall_i,
  input  logic detl_fall_i,
  output logic evt_o
);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // Window opens on gate fall; a detect-low fall while it is open is an event
  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    evt_o = 1'b0;
    if (gate_fall_i) begin
      if (detl_fall_i) begin
        evt_o = 1'b1;
        run_d = 1'b0;
      end else begin
        run_d = 1'b1;
        cnt_d = CW'(1);
      end
    end else if (run_q) begin
      if (detl_fall_i) begin
        evt_o = 1'b1;
        run_d = 1'b0;
      end else if (cnt_q == CW'(DW_TICKS)) begin
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/srs_ring_det.sv
module srs_ring_det
  import srs_pkg::*;
#(
  parameter int unsigned RING_WIN  = 70,
  parameter int unsigned RING_HOLD = 30,
  localparam int unsigned WW = $clog2(RING_WIN + 1),
  localparam int unsigned HW = $clog2(RING_HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic detl_i,
  input  logic detl_rise_i,
  input  logic detl_fall_i,
  output logic evt_o
);

  ring_state_e   st_q, st_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [HW-1:0] hcnt_q, hcnt_d;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    hcnt_d = hcnt_q;
    evt_o  = 1'b0;
    unique case (st_q)
      RG_IDLE: begin
        if (detl_rise_i) begin
          st_d   = RG_WIN;
          wcnt_d = WW'(1);
        end
      end
      RG_WIN: begin
        if (detl_fall_i) begin
          st_d   = RG_HOLD;
          hcnt_d = '0;
        end else if (wcnt_q == WW'(RING_WIN)) begin
          st_d = RG_IDLE;
        end else begin
          wcnt_d = wcnt_q + WW'(1);
        end
      end
      RG_HOLD: begin
        if (detl_i) begin
          // bounced back before the hold completed: new pulse window
          st_d   = RG_WIN;
          wcnt_d = WW'(1);
        end else if (hcnt_q + HW'(1) == HW'(RING_HOLD)) begin
          evt_o = 1'b1;
          st_d  = RG_IDLE;
        end else begin
          hcnt_d = hcnt_q + HW'(1);
        end
      end
      default: st_d = RG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RG_IDLE;
      wcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      hcnt_q <= hcnt_d;
    end
  end

endmodule

// File: rtl/srs_fb_det.sv
module srs_fb_det #(
  parameter int unsigned FB_W    = 10,
  parameter int unsigned FD_HOLD = 18000,
  localparam int unsigned PW  = FB_W + 3,
  localparam int unsigned TW  = $clog2(FD_HOLD + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fb_val_i,
  input  logic [FB_W-1:0] fb_word_i,
  output logic            trig_o,
  output logic            active_o
);

  logic [FB_W-1:0] prev_q, prev_d;
  logic            prev_en;
  logic [TW-1:0]   tmr_q, tmr_d;
  logic [PW-1:0]   new_x5, old_x6;

  // Growth above 20%: 5*new > 6*old, no divider
  always_comb begin
    new_x5  = PW'(fb_word_i) * PW'(5);
    old_x6  = PW'(prev_q) * PW'(6);
    trig_o  = fb_val_i && (new_x5 > old_x6);
    prev_en = fb_val_i;
    prev_d  = fb_word_i;
    if (trig_o)              tmr_d = TW'(FD_HOLD);
    else if (tmr_q != '0)    tmr_d = tmr_q - TW'(1);
    else                     tmr_d = tmr_q;
  end

  assign active_o = (tmr_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      tmr_q  <= '0;
    end else begin
      if (prev_en) prev_q <= prev_d;
      tmr_q <= tmr_d;
    end
  end

endmodule

// File: rtl/srs_shrink_arb.sv
module srs_shrink_arb
  import srs_pkg::*;
#(
  parameter int unsigned FB_W       = 10,
  parameter int unsigned DW_TICKS   = 25,
  parameter int unsigned RING_WIN   = 70,
  parameter int unsigned RING_HOLD  = 30,
  parameter int unsigned DT_SHRINK  = 250,
  parameter int unsigned FD_SHRINK  = 280,
  parameter int unsigned RNG_SHRINK = 240,
  parameter int unsigned FD_HOLD    = 18000,
  localparam int unsigned MAX_SHR   = max3(DT_SHRINK, FD_SHRINK, RNG_SHRINK),
  localparam int unsigned SHR_W     = $clog2(MAX_SHR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             detl_i,
  input  logic             fb_val_i,
  input  logic [FB_W-1:0]  fb_word_i,
  input  logic             cyc_start_i,
  output logic [SHR_W-1:0] shrink_o
);

  logic gate_q, detl_q;
  logic gate_fall, detl_fall, detl_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      detl_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      detl_q <= detl_i;
    end
  end

  assign gate_fall = gate_q & ~gate_i;
  assign detl_fall = detl_q & ~detl_i;
  assign detl_rise = ~detl_q & detl_i;

  logic [NUM_CYC_SRC-1:0] cyc_evt;
  logic [NUM_CYC_SRC-1:0] hold_act;
  logic                   fd_trig, fd_active;

  srs_deadtime_det #(.DW_TICKS(DW_TICKS)) u_dt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gate_fall_i (gate_fall),
    .detl_fall_i (detl_fall),
    .evt_o       (cyc_evt[SRC_DT])
  );

  srs_ring_det #(.RING_WIN(RING_WIN), .RING_HOLD(RING_HOLD)) u_rng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .detl_i      (detl_i),
    .detl_rise_i (detl_rise),
    .detl_fall_i (detl_fall),
    .evt_o       (cyc_evt[SRC_RNG])
  );

  srs_fb_det #(.FB_W(FB_W), .FD_HOLD(FD_HOLD)) u_fb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fb_val_i  (fb_val_i),
    .fb_word_i (fb_word_i),
    .trig_o    (fd_trig),
    .active_o  (fd_active)
  );

  // Arm-then-apply holders for the one-cycle sources
  for (genvar g = 0; g < NUM_CYC_SRC; g++) begin : g_cyc
    logic pend_q, pend_d, act_q, act_d;

    always_comb begin
      pend_d = pend_q | cyc_evt[g];
      act_d  = act_q;
      if (cyc_start_i) begin
        act_d  = pend_q;
        pend_d = cyc_evt[g];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        act_q  <= 1'b0;
      end else begin
        pend_q <= pend_d;
        act_q  <= act_d;
      end
    end

    assign hold_act[g] = act_q;
  end

  // Largest active amount wins
  logic [SHR_W-1:0] amt [NUM_SRC];
  logic [NUM_SRC-1:0] src_on;

  assign amt[SRC_DT]      = SHR_W'(DT_SHRINK);
  assign amt[SRC_RNG]     = SHR_W'(RNG_SHRINK);
  assign amt[NUM_CYC_SRC] = SHR_W'(FD_SHRINK);
  assign src_on = {fd_active, hold_act};

  always_comb begin
    shrink_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_on[i] && (amt[i] > shrink_o)) shrink_o = amt[i];
    end
  end

endmodule

// File: rtl/srs_shrink_arb_chk.sv
module srs_shrink_arb_chk #(
  parameter int unsigned SHR_W      = 9,
  parameter int unsigned DT_SHRINK  = 250,
  parameter int unsigned FD_SHRINK  = 280,
  parameter int unsigned RNG_SHRINK = 240
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic [SHR_W-1:0] shrink,
  input logic             fd_active,
  input logic             fd_trig,
  input logic [1:0]       hold_act
);

  // R5: a trigger turns the feedback hold on at the next edge
  assert_fd_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fd_trig |=> fd_active);

  // R5: while the feedback hold runs, output never drops below its amount
  assert_fd_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fd_active |-> (int'(shrink) >= int'(FD_SHRINK)));

  // R3: one-cycle sources only move on a cycle-start strobe
  assert_cycle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(hold_act));

  // R9: output is one of the amounts, never a sum
  assert_no_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(shrink) == 0) || (int'(shrink) == int'(DT_SHRINK)) ||
    (int'(shrink) == int'(FD_SHRINK)) || (int'(shrink) == int'(RNG_SHRINK)));

  // R9: nothing active means no shrink
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fd_active && (hold_act == 2'b00)) |-> (shrink == '0));

endmodule

bind srs_shrink_arb srs_shrink_arb_chk #(
  .SHR_W      (SHR_W),
  .DT_SHRINK  (DT_SHRINK),
  .FD_SHRINK  (FD_SHRINK),
  .RNG_SHRINK (RNG_SHRINK)
) chk_i (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .cyc_start (cyc_start_i),
  .shrink    (shrink_o),
  .fd_active (fd_active),
  .fd_trig   (fd_trig),
  .hold_act  (hold_act)
);

// File: tb/srs_shrink_arb_tb.sv
`timescale 1ns/1ps
module srs_shrink_arb_tb_top;

  localparam int FB_W = 8;
  localparam int DW   = 4;
  localparam int RW   = 6;
  localparam int RH   = 3;
  localparam int DT   = 10;
  localparam int FD   = 12;
  localparam int RNG  = 9;
  localparam int HOLD = 20;
  localparam int SHR_W = $clog2(FD + 1);

  logic clk = 1'b0;
  logic rst_n, gate, detl, fb_val, cyc;
  logic [FB_W-1:0]  fb_word;
  logic [SHR_W-1:0] shrink;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  srs_shrink_arb #(
    .FB_W(FB_W), .DW_TICKS(DW), .RING_WIN(RW), .RING_HOLD(RH),
    .DT_SHRINK(DT), .FD_SHRINK(FD), .RNG_SHRINK(RNG), .FD_HOLD(HOLD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .detl_i(detl),
    .fb_val_i(fb_val), .fb_word_i(fb_word), .cyc_start_i(cyc),
    .shrink_o(shrink)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gate = 1'b0; detl = 1'b0; fb_val = 1'b0;
    fb_word = '0; cyc = 1'b0;
    tick(2);
    check("R1 reset", int'(shrink), 0);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_cyc();
    cyc = 1'b1; tick(1); cyc = 1'b0;
  endtask

  task automatic strobe(input int w);
    fb_word = FB_W'(w); fb_val = 1'b1; tick(1); fb_val = 1'b0;
  endtask

  initial begin
    int cnt;
    // reset state and first-sample growth
    do_reset();
    check("R1 idle", int'(shrink), 0);
    strobe(1);
    check("R1 first sample after reset", int'(shrink), FD);

    // R2/R3: dead-time window sweep
    for (int d = 0; d <= DW + 4; d++) begin
      do_reset();
      gate = 1'b1; detl = 1'b1; tick(10);
      gate = 1'b0;
      if (d == 0) detl = 1'b0;
      tick(1);
      if (d > 0) begin
        tick(d - 1); detl = 1'b0; tick(1);
      end
      tick(12);
      check("R3 no shrink before cycle start", int'(shrink), 0);
      pulse_cyc();
      check("R2 dead-time window", int'(shrink), (d <= DW) ? DT : 0);
      tick(3);
      check("R3 held in cycle", int'(shrink), (d <= DW) ? DT : 0);
      pulse_cyc();
      check("R3 dropped next cycle", int'(shrink), 0);
    end

    // R7/R8: ringing sweep
    for (int d = 1; d <= RW + 2; d++) begin
      for (int h = 0; h <= RH + 2; h++) begin
        do_reset();
        tick(10);
        detl = 1'b1; tick(1);
        tick(d - 1); detl = 1'b0; tick(1);
        tick(h); detl = 1'b1; tick(12);
        check("R8 no shrink before cycle start", int'(shrink), 0);
        pulse_cyc();
        check("R7 ringing detect", int'(shrink), (d <= RW && h >= RH) ? RNG : 0);
        pulse_cyc();
        check("R8 one cycle only", int'(shrink), 0);
      end
    end

    // R4: strict 5:6 growth test
    for (int a = 1; a <= 12; a++) begin
      for (int b = 0; b <= 20; b++) begin
        do_reset();
        strobe(a);
        tick(HOLD + 2);
        strobe(b);
        check("R4 growth compare", int'(shrink), (5 * b > 6 * a) ? FD : 0);
      end
    end

    // R5: exact hold length
    do_reset();
    cnt = 0;
    for (int n = 0; n < HOLD + 6; n++) begin
      fb_val = (n == 0); fb_word = 8'd50; tick(1);
      if (int'(shrink) == FD) cnt++;
    end
    fb_val = 1'b0;
    check("R5 hold length", cnt, HOLD);

    // R5: restart mid-hold
    do_reset();
    cnt = 0;
    for (int n = 0; n < HOLD + 16; n++) begin
      fb_val = (n == 0 || n == 10);
      fb_word = (n == 10) ? 8'd70 : 8'd50;
      tick(1);
      if (int'(shrink) == FD) cnt++;
    end
    fb_val = 1'b0;
    check("R5 retrigger restarts hold", cnt, HOLD + 10);

    // R6: stored value replaced on non-triggering strobe
    do_reset();
    strobe(10); tick(HOLD + 2);
    strobe(12); tick(1);
    check("R6 exact 20% no trigger", int'(shrink), 0);
    strobe(14);
    check("R6 compare against latest sample", int'(shrink), 0);

    // R10: unstrobed word ignored
    do_reset();
    strobe(10); tick(HOLD + 2);
    fb_word = 8'd1; tick(5);
    check("R10 no effect without strobe", int'(shrink), 0);
    strobe(11);
    check("R10 previous value kept", int'(shrink), 0);

    // R9: dead-time plus ringing in same cycle
    do_reset();
    gate = 1'b1; detl = 1'b1; tick(10);
    gate = 1'b0; tick(1); detl = 1'b0; tick(1);
    tick(1); detl = 1'b1; tick(1); detl = 1'b0; tick(RH + 3);
    pulse_cyc();
    check("R9 max of dead-time and ringing", int'(shrink), DT);

    // R9: feedback over dead-time
    do_reset();
    gate = 1'b1; detl = 1'b1; tick(10);
    gate = 1'b0; tick(1); detl = 1'b0; tick(10);
    cyc = 1'b1; fb_word = 8'd40; fb_val = 1'b1; tick(1);
    cyc = 1'b0; fb_val = 1'b0;
    check("R9 max of feedback and dead-time", int'(shrink), FD);
    tick(HOLD + 1);
    check("R9 dead-time after feedback expires", int'(shrink), DT);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule